// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits on the requesting side of a pipelined on-chip bus and produces the address-phase signals for one burst at a time: the byte address of each beat and the transfer-type code that says whether the bus is idle, paused, opening a burst or continuing one. The surrounding logic gives it a start address, a burst kind, a transfer size and a start pulse. The sequencer then steps through the beats, honouring the bus-ready signal from the addressed target and a stall input that lets the surrounding logic pause between beats.

It handles single transfers, incrementing bursts whose length comes from a separate length input, and fixed bursts of 4, 8 and 16 beats in incrementing and wrapping forms. The wrap window is the beat count shifted by the transfer size. Requests that would break the bus rules are refused at the start: a misaligned address, a size wider than the bus, a zero length, or a fixed incrementing burst that runs past a 1 KB page. A length-driven incrementing burst is cut short at the page edge rather than refused. A one-cycle flag marks the end of a burst and another marks a refusal.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `htrans_o` is IDLE (2'b00), `haddr_o` is zero, and `done_o` and `err_o` are low.
- R2: Transfer codes are IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10 and SEQ=2'b11. When `start_i` is sampled high with `htrans_o` at IDLE and the request is legal, the next cycle shows NONSEQ at `start_addr_i`. Every later beat of the same burst is SEQ. After IDLE, only IDLE or NONSEQ may follow.
- R3: The `burst_i` codes are 0 single (1 beat), 1 length-driven incrementing (`incr_len_i` beats), 2 wrap-4, 3 incr-4, 4 wrap-8, 5 incr-8, 6 wrap-16 and 7 incr-16. When the last beat is accepted (NONSEQ or SEQ with `ready_i` high at the edge), the next cycle shows IDLE with `done_o` high for exactly one cycle.
- R4: In an incrementing burst, each beat's address is the previous beat's address plus 2^`size_i` bytes.
- R5: In a wrapping burst, addresses increase by 2^`size_i` and wrap within the aligned window of (beat count × 2^`size_i`) bytes that contains the start address.
- R6: A start with a start address not aligned to 2^`size_i`, a `size_i` above 2 (wider than the 32-bit bus), or burst code 1 with `incr_len_i` of zero is refused. `err_o` is high for one cycle in the next cycle, `htrans_o` stays IDLE, and no beat is issued. Every NONSEQ or SEQ address is aligned to its size.
- R7: A fixed incrementing burst (codes 3, 5, 7) whose bytes would run past the end of the current 1 KB page is refused, in the same way as R6.
- R8: A length-driven incrementing burst that would cross a 1 KB page is shortened so that its last beat is the last one inside the page.
- R9: If `stall_i` is high at the edge that accepts a non-final beat, the next cycle shows BUSY with the address of the following beat. BUSY repeats with that address held while `stall_i` stays high. The first edge with `ready_i` high and `stall_i` low turns it into SEQ at the same address.
- R10: While a burst is active and `ready_i` is low, `haddr_o` and `htrans_o` hold their values into the next cycle.
- R11: `start_i` is ignored while a burst is active (any code other than IDLE on `htrans_o`). The beats in progress are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a burst, sampled while idle |
| start_addr_i | input | ADDR_W | Byte address of the first beat |
| burst_i | input | 3 | Burst kind code (see R3) |
| size_i | input | 3 | Transfer size as log2 of bytes per beat |
| incr_len_i | input | LEN_W | Beat count for the length-driven incrementing burst |
| stall_i | input | 1 | Insert BUSY before the next beat |
| ready_i | input | 1 | Bus ready; an address phase advances only when high |
| haddr_o | output | ADDR_W | Address of the current beat |
| htrans_o | output | 2 | Transfer type code |
| done_o | output | 1 | One-cycle pulse after the last beat is accepted |
| err_o | output | 1 | One-cycle pulse after a refused start |

## Verification
Directed bursts pin down exact address lists. A wrap-4 that starts mid-window shows whether the wrap happens at the window edge or at a fixed alignment. A length-driven burst starting a few words below a 1 KB edge shows truncation. A fixed burst at the same place shows refusal, and misaligned or oversized requests show the error path. Random bursts then mix every burst code and size with random ready waits and stalls. These runs separate a correct hold during ready-low cycles from one that advances anyway. They also show whether BUSY carries the next address rather than the current one. Stray start pulses injected during active bursts confirm that they are ignored.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_t;

  localparam logic [2:0] BK_SINGLE = 3'd0;
  localparam logic [2:0] BK_INCR   = 3'd1;
  localparam logic [2:0] BK_WRAP4  = 3'd2;
  localparam logic [2:0] BK_INCR4  = 3'd3;
  localparam logic [2:0] BK_WRAP8  = 3'd4;
  localparam logic [2:0] BK_INCR8  = 3'd5;
  localparam logic [2:0] BK_WRAP16 = 3'd6;
  localparam logic [2:0] BK_INCR16 = 3'd7;

endpackage

// File: rtl/burst_plan.sv
// Decodes a start request: legality, beat count and wrap window mask.
module burst_plan
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 8,
  parameter int MAX_SIZE = 2,
  parameter int PAGE_LG  = 10,
  parameter int CNT_W    = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        burst_i,
  input  logic [2:0]        size_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              ok_o,
  output logic [CNT_W-1:0]  beats_o,
  output logic [ADDR_W-1:0] wrap_mask_o
);
  localparam int PAGE_W = PAGE_LG + 1;
  localparam int CMP_W  = (CNT_W > PAGE_W) ? CNT_W : PAGE_W;
  localparam logic [PAGE_W-1:0] PAGE_BYTES = PAGE_W'(1) << PAGE_LG;

  logic [4:0]        fixed_beats;
  logic              is_wrap, is_fixed_incr, is_len_incr;
  logic [PAGE_W-1:0] offset, room, room_beats, span;
  logic [ADDR_W-1:0] align_mask;
  logic              misaligned, too_wide, bad_len, over_page;
  logic [CMP_W-1:0]  len_ext, room_ext;

  always_comb begin
    case (burst_i[2:1])
      2'b00:   fixed_beats = 5'd1;
      2'b01:   fixed_beats = 5'd4;
      2'b10:   fixed_beats = 5'd8;
      default: fixed_beats = 5'd16;
    endcase
  end

  assign is_len_incr   = (burst_i == BK_INCR);
  assign is_wrap       = (burst_i[0] == 1'b0) && (burst_i != BK_SINGLE);
  assign is_fixed_incr = burst_i[0] && !is_len_incr;

  assign offset     = {1'b0, addr_i[PAGE_LG-1:0]};
  assign room       = PAGE_BYTES - offset;
  assign room_beats = room >> size_i;
  assign span       = PAGE_W'(fixed_beats) << size_i;

  assign align_mask = ~({ADDR_W{1'b1}} << size_i);
  assign misaligned = (addr_i & align_mask) != '0;
  assign too_wide   = size_i > 3'(MAX_SIZE);
  assign bad_len    = is_len_incr && (len_i == '0);
  assign over_page  = is_fixed_incr && (span > room);

  assign ok_o = !misaligned && !too_wide && !bad_len && !over_page;

  assign len_ext  = CMP_W'(len_i);
  assign room_ext = CMP_W'(room_beats);

  always_comb begin
    if (is_len_incr)
      beats_o = (len_ext < room_ext) ? CNT_W'(len_ext) : CNT_W'(room_ext);
    else
      beats_o = CNT_W'(fixed_beats);
  end

  assign wrap_mask_o = is_wrap ? ADDR_W'(span - PAGE_W'(1)) : {ADDR_W{1'b1}};

endmodule

// File: rtl/burst_step.sv
// Next-beat address: add the stride, keep the bits outside the wrap window.
module burst_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [ADDR_W-1:0] wrap_mask_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] stride, sum;

  assign stride = ADDR_W'(1) << size_i;
  assign sum    = addr_i + stride;
  assign next_o = (addr_i & ~wrap_mask_i) | (sum & wrap_mask_i);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 8,
  parameter int MAX_SIZE = 2,
  parameter int PAGE_LG  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [2:0]        burst_i,
  input  logic [2:0]        size_i,
  input  logic [LEN_W-1:0]  incr_len_i,
  input  logic              stall_i,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] haddr_o,
  output logic [1:0]        htrans_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int CNT_W = (LEN_W > 5) ? LEN_W : 5;

  trans_t            tr_q;
  logic [ADDR_W-1:0] haddr_q, wrap_mask_q, step_addr;
  logic [2:0]        size_q;
  logic [CNT_W-1:0]  remaining_q;
  logic              done_q, err_q;

  logic              plan_ok;
  logic [CNT_W-1:0]  plan_beats;
  logic [ADDR_W-1:0] plan_mask;

  burst_plan #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_SIZE(MAX_SIZE),
    .PAGE_LG(PAGE_LG), .CNT_W(CNT_W)
  ) u_plan (
    .addr_i     (start_addr_i),
    .burst_i    (burst_i),
    .size_i     (size_i),
    .len_i      (incr_len_i),
    .ok_o       (plan_ok),
    .beats_o    (plan_beats),
    .wrap_mask_o(plan_mask)
  );

  burst_step #(.ADDR_W(ADDR_W)) u_step (
    .addr_i     (haddr_q),
    .size_i     (size_q),
    .wrap_mask_i(wrap_mask_q),
    .next_o     (step_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tr_q        <= TR_IDLE;
      haddr_q     <= '0;
      wrap_mask_q <= '1;
      size_q      <= '0;
      remaining_q <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (tr_q)
        TR_IDLE: begin
          if (start_i) begin
            if (plan_ok) begin
              tr_q        <= TR_NONSEQ;
              haddr_q     <= start_addr_i;
              size_q      <= size_i;
              wrap_mask_q <= plan_mask;
              remaining_q <= plan_beats - CNT_W'(1);
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        TR_NONSEQ, TR_SEQ: begin
          if (ready_i) begin
            if (remaining_q == '0) begin
              tr_q   <= TR_IDLE;
              done_q <= 1'b1;
            end else begin
              remaining_q <= remaining_q - CNT_W'(1);
              haddr_q     <= step_addr;
              tr_q        <= stall_i ? TR_BUSY : TR_SEQ;
            end
          end
        end
        default: begin
          if (ready_i && !stall_i) tr_q <= TR_SEQ;
        end
      endcase
    end
  end

  assign haddr_o  = haddr_q;
  assign htrans_o = tr_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              ready_i,
  input logic [ADDR_W-1:0] haddr_o,
  input logic [1:0]        htrans_o,
  input logic              done_o,
  input logic              err_o,
  input logic [2:0]        size_q
);
  logic [ADDR_W-1:0] amask;
  assign amask = ~({ADDR_W{1'b1}} << size_q);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!ready_i && htrans_o != 2'b00) |=> ($stable(haddr_o) && $stable(htrans_o)));

  assert_busy_next_R9: assert property (@(posedge clk) disable iff (rst)
    (htrans_o == 2'b01 && ready_i) |=>
      ($stable(haddr_o) && (htrans_o == 2'b01 || htrans_o == 2'b11)));

  assert_idle_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (htrans_o == 2'b00) |=> (htrans_o == 2'b00 || htrans_o == 2'b10));

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (htrans_o == 2'b00 && $past(ready_i) && $past(htrans_o[1])));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_err_idle_R6: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (htrans_o == 2'b00 && !done_o && $past(start_i)));

  assert_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    htrans_o[1] |-> ((haddr_o & amask) == '0));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .ready_i (ready_i),
  .haddr_o (haddr_o),
  .htrans_o(htrans_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .size_q  (size_q)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [2:0]  burst_i = '0;
  logic [2:0]  size_i = '0;
  logic [7:0]  incr_len_i = '0;
  logic        stall_i = 1'b0;
  logic        ready_i = 1'b1;
  logic [31:0] haddr_o;
  logic [1:0]  htrans_o;
  logic        done_o, err_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  burst_addr_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .burst_i(burst_i), .size_i(size_i), .incr_len_i(incr_len_i),
    .stall_i(stall_i), .ready_i(ready_i), .haddr_o(haddr_o),
    .htrans_o(htrans_o), .done_o(done_o), .err_o(err_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int nbeats(input logic [2:0] b, input int len, input logic [31:0] a, input int sz);
    int room;
    room = (1024 - int'(a % 1024)) / (1 << sz);
    case (b)
      3'd0: return 1;
      3'd1: return (len < room) ? len : room;
      3'd2, 3'd3: return 4;
      3'd4, 3'd5: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic bit is_legal(input logic [2:0] b, input int len, input logic [31:0] a, input int sz);
    int by;
    if (sz > 2) return 0;
    by = 1 << sz;
    if ((a % by) != 0) return 0;
    if (b == 3'd1 && len == 0) return 0;
    if ((b == 3'd3 || b == 3'd5 || b == 3'd7) &&
        (int'(a % 1024) + nbeats(b, len, a, sz) * by > 1024)) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] beat_addr(input logic [31:0] a, input logic [2:0] b, input int sz,
                                            input int len, input int k);
    logic [31:0] by, blk, base;
    by = 32'(1 << sz);
    if (b != 3'd0 && b[0] == 1'b0) begin
      blk  = 32'(nbeats(b, len, a, sz)) * by;
      base = a & ~(blk - 1);
      return base + ((a - base + 32'(k) * by) % blk);
    end
    return a + 32'(k) * by;
  endfunction

  task automatic run_burst(input logic [31:0] a, input logic [2:0] b, input int sz, input int len,
                           input int stall_pct, input int wait_pct);
    int n, k, got;
    logic [1:0] etr;
    bit edone, fin, r, s;
    string atag;
    atag = (b != 3'd0 && b[0] == 1'b0) ? "R5" : "R4";
    @(negedge clk);
    chk("R3 done low between bursts", 32'(done_o), 0);
    start_i = 1'b1; start_addr_i = a; burst_i = b; size_i = 3'(sz); incr_len_i = 8'(len);
    ready_i = ($urandom % 100) >= 32'(wait_pct);
    @(negedge clk);
    start_i = 1'b0;
    if (!is_legal(b, len, a, sz)) begin
      chk("R6/R7 err pulse", 32'(err_o), 1);
      chk("R6/R7 stays idle", 32'(htrans_o), 0);
      @(negedge clk);
      chk("R6 err one cycle", 32'(err_o), 0);
      chk("R6 no beat issued", 32'(htrans_o), 0);
      return;
    end
    n = nbeats(b, len, a, sz);
    etr = 2'b10; k = 0; edone = 0; fin = 0; got = 0;
    while (!fin) begin
      chk("R2/R9/R10/R11 htrans", 32'(htrans_o), 32'(etr));
      chk("R3 done", 32'(done_o), 32'(edone));
      chk("R6 no err", 32'(err_o), 0);
      if (etr != 2'b00) chk(atag, haddr_o, beat_addr(a, b, sz, len, k));
      if (edone) begin
        fin = 1;
      end else begin
        r = ($urandom % 100) >= 32'(wait_pct);
        s = ($urandom % 100) < 32'(stall_pct);
        ready_i = r; stall_i = s;
        start_i = ($urandom % 8) == 0; // R11 stray start while active
        start_addr_i = $urandom; burst_i = 3'($urandom);
        @(negedge clk);
        start_i = 1'b0;
        if (r) begin
          if (etr[1]) begin
            got = got + 1;
            if (k == n - 1) begin etr = 2'b00; edone = 1; end
            else begin k = k + 1; etr = s ? 2'b01 : 2'b11; end
          end else if (etr == 2'b01) begin
            etr = s ? 2'b01 : 2'b11;
          end
        end
      end
    end
    if (b == 3'd1 && n < len) chk("R8 truncated beat count", 32'(got), 32'(n));
    else chk("R3 beat count", 32'(got), 32'(n));
    ready_i = 1'b1; stall_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk("R1 htrans in reset", 32'(htrans_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 htrans idle", 32'(htrans_o), 0);
    chk("R1 haddr zero", haddr_o, 0);
    chk("R1 done low", 32'(done_o), 0);
    chk("R1 err low", 32'(err_o), 0);

    // Directed corners
    run_burst(32'h0000_1038, 3'd2, 2, 0, 0, 0);   // R5 wrap-4: 38,3C,30,34
    chk("R5 hand value", beat_addr(32'h1038, 3'd2, 2, 0, 2), 32'h1030);
    run_burst(32'h0000_2006, 3'd6, 1, 0, 0, 0);   // R5 wrap-16 halfwords
    run_burst(32'h0000_0100, 3'd0, 2, 0, 0, 0);   // single
    run_burst(32'h0000_03F8, 3'd1, 2, 10, 0, 0);  // R8 cut to 2 beats
    run_burst(32'h0000_07FF, 3'd1, 0, 5, 0, 0);   // R8 cut to 1 beat
    run_burst(32'h0000_03F8, 3'd3, 2, 0, 0, 0);   // R7 refused
    run_burst(32'h0000_03F0, 3'd3, 2, 0, 0, 0);   // R7 fits exactly
    run_burst(32'h0000_0002, 3'd5, 2, 0, 0, 0);   // R6 misaligned
    run_burst(32'h0000_0000, 3'd5, 3, 0, 0, 0);   // R6 too wide
    run_burst(32'h0000_0040, 3'd1, 2, 0, 0, 0);   // R6 zero length
    run_burst(32'h0000_0400, 3'd7, 2, 0, 60, 0);  // R9 heavy stalls
    run_burst(32'h0000_0800, 3'd4, 2, 0, 0, 60);  // R10 heavy waits

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      int sz, len;
      sz = int'($urandom % 4);
      a = $urandom;
      if (($urandom % 8) != 0) a = a & ~32'((1 << sz) - 1);
      if (($urandom % 4) == 0) a = a | 32'h0000_03C0;
      len = int'($urandom % 40);
      run_burst(a, 3'($urandom), sz, len, ($urandom % 2) ? 30 : 0, ($urandom % 2) ? 30 : 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule